// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's control path. Each cycle it looks at a pending exception code and a pending external interrupt, decides whether either is taken, and, if one is, loads in one clock edge every piece of processor state that changes on handler entry. It keeps a held copy of the status register, program counter, saved status, saved PC, saved stack pointer, and the exception and interrupt event registers. The core reads these back and writes them into its own architectural state when the taken strobe fires.

Exceptions always take priority. While the status register's block bit is set, the core is not allowed to take a nested fault. Any exception except one code is then promoted to a reset, and interrupts wait unless the core is asleep. The handler address is chosen by cause: a fixed reset address, a TLB-miss entry, a general entry and an interrupt entry, each offset from the vector base. The saved PC is adjusted for delay slots and for the trap instruction. The block also sends the current interrupt mask level to the interrupt controller. The controller replies with a vector, and all ones in that vector means nothing can be delivered.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid` is high, the exception is taken (`taken` high, `irq_ack` low on the next cycle) whatever the interrupt inputs are. An interrupt is only considered when `exc_valid` is low.
- R2: If status bit 28 (block) is set, a pending exception with any code except 0x1E0 is entered as code 0x000 (reset). Code 0x1E0 keeps its own code.
- R3: `irq_level` always equals status bits 7:4. A request with block bit 28 set is ignored unless `in_sleep` is high. A vector of all ones is ignored. An ignored request changes no output.
- R4: On entry, `ssr_q` takes the old status register and `sgr_q` takes `r15_in`. In `sr_q`, bits 28, 29 and 30 are set and all other bits are kept, except as R6 states.
- R5: `spc_q` takes `pc_in`, minus 2 when `dslot_in[0]` or `dslot_in[1]` is set. `dslot_q` is cleared on entry; otherwise it copies `dslot_in` one cycle later.
- R6: Codes 0x000 and 0x020 clear status bit 15, set bits 7:4 to 1111 and load `pc_q` with 0xA0000000.
- R7: Codes 0x040 and 0x060 load `pc_q` with `vbr_in`+0x400. Every other exception loads `vbr_in`+0x100.
- R8: A taken interrupt loads `pc_q` with `vbr_in`+0x600 and `intevt_q` with the vector, raises `irq_ack`, and leaves `expevt_q` unchanged.
- R9: For trap code 0x160, `spc_q` is 2 higher than R5 alone gives.
- R10: A taken exception writes its effective code into `expevt_q`. `intevt_q` is left unchanged.
- R11: `taken` and every register update occur on the clock edge that samples the request. With nothing taken, all held registers keep their values. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception pending |
| exc_code | input | CODE_W | Pending exception code |
| irq_req | input | 1 | External interrupt pending |
| irq_vector | input | CODE_W | Vector from the controller, all ones = none |
| irq_level | output | 4 | Current mask level sent to the controller |
| sr_in | input | XLEN | Current status register |
| pc_in | input | XLEN | Current PC |
| vbr_in | input | XLEN | Vector base |
| r15_in | input | XLEN | General register 15 |
| in_sleep | input | 1 | Core is sleeping |
| dslot_in | input | 3 | Delay-slot flags (bit0 plain, bit1 conditional, bit2 branch-true) |
| taken | output | 1 | Entry performed this cycle |
| irq_ack | output | 1 | The entry was an interrupt |
| sr_q | output | XLEN | New status register |
| pc_q | output | XLEN | Handler address |
| ssr_q | output | XLEN | Saved status |
| spc_q | output | XLEN | Saved PC |
| sgr_q | output | XLEN | Saved register 15 |
| expevt_q | output | CODE_W | Exception event |
| intevt_q | output | CODE_W | Interrupt event |
| dslot_q | output | 3 | Delay-slot flags after entry |

## Verification
The assertions check on every cycle that exceptions take priority, that a blocked exception is promoted to reset, that an interrupt under the block bit waits while the core is awake, that the entry bits are set and the old status register is saved, that interrupt entries load the vector and the right address, and that idle cycles hold state. The bench sweeps the cause-code set against the block bit, the sleep flag, the delay-slot flags and a valid or empty vector, and compares every output against an arithmetic model. Only these scenarios show the saved-PC arithmetic for delay slots and traps, the reset changes to the status register, the split between the TLB-miss and general entry addresses, and the delay-slot clear.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // status register bit positions (decoded by the core)
  localparam int SR_BL    = 28;
  localparam int SR_RB    = 29;
  localparam int SR_MD    = 30;
  localparam int SR_FD    = 15;
  localparam int SR_IM_LO = 4;
  localparam int IM_W     = 4;
  localparam int DS_W     = 3;

  // cause codes
  localparam int CODE_PWR_RST = 'h000;
  localparam int CODE_MAN_RST = 'h020;
  localparam int CODE_TLB_LD  = 'h040;
  localparam int CODE_TLB_ST  = 'h060;
  localparam int CODE_TRAP    = 'h160;
  localparam int CODE_KEEP_BL = 'h1E0;

  // handler placement
  localparam longint RESET_PC = 64'h0000_0000_A000_0000;
  localparam int OFS_TLB = 'h400;
  localparam int OFS_GEN = 'h100;
  localparam int OFS_IRQ = 'h600;

  typedef enum logic [2:0] {
    CAUSE_NONE,
    CAUSE_RESET,
    CAUSE_TLB,
    CAUSE_GEN,
    CAUSE_IRQ
  } cause_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [CODE_W-1:0] irq_vector,
  input  logic              blocked,
  input  logic              in_sleep,
  output logic              take,
  output logic [CODE_W-1:0] eff_code,
  output cause_e            cause
);
  logic irq_ok;

  always_comb begin
    irq_ok   = irq_req && !exc_valid && (!blocked || in_sleep) && !(&irq_vector);
    eff_code = exc_code;
    if (blocked && exc_code != CODE_W'(CODE_KEEP_BL)) begin
      eff_code = CODE_W'(CODE_PWR_RST);
    end
    cause = CAUSE_NONE;
    if (exc_valid) begin
      if (eff_code == CODE_W'(CODE_PWR_RST) || eff_code == CODE_W'(CODE_MAN_RST)) begin
        cause = CAUSE_RESET;
      end else if (eff_code == CODE_W'(CODE_TLB_LD) || eff_code == CODE_W'(CODE_TLB_ST)) begin
        cause = CAUSE_TLB;
      end else begin
        cause = CAUSE_GEN;
      end
    end else if (irq_ok) begin
      cause = CAUSE_IRQ;
    end
    take = (cause != CAUSE_NONE);
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  cause_e            cause,
  input  logic [CODE_W-1:0] eff_code,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic [1:0]        in_slot,
  output logic [XLEN-1:0]   sr_nx,
  output logic [XLEN-1:0]   pc_nx,
  output logic [XLEN-1:0]   spc_nx
);
  logic [XLEN-1:0] adj;

  always_comb begin
    sr_nx         = sr_in;
    sr_nx[SR_BL]  = 1'b1;
    sr_nx[SR_RB]  = 1'b1;
    sr_nx[SR_MD]  = 1'b1;
    pc_nx         = vbr_in + XLEN'(OFS_GEN);
    case (cause)
      CAUSE_RESET: begin
        sr_nx[SR_FD]                = 1'b0;
        sr_nx[SR_IM_LO +: IM_W]     = '1;
        pc_nx                       = XLEN'(RESET_PC);
      end
      CAUSE_TLB: pc_nx = vbr_in + XLEN'(OFS_TLB);
      CAUSE_IRQ: pc_nx = vbr_in + XLEN'(OFS_IRQ);
      default:   pc_nx = vbr_in + XLEN'(OFS_GEN);
    endcase

    // one adder: -2 for a delay slot, +2 for a trap, combined
    adj = '0;
    if (|in_slot) adj = adj - XLEN'(2);
    if (cause == CAUSE_GEN && eff_code == CODE_W'(CODE_TRAP)) adj = adj + XLEN'(2);
    spc_nx = pc_in + adj;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [CODE_W-1:0] irq_vector,
  output logic [3:0]        irq_level,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic              in_sleep,
  input  logic [2:0]        dslot_in,
  output logic              taken,
  output logic              irq_ack,
  output logic [XLEN-1:0]   sr_q,
  output logic [XLEN-1:0]   pc_q,
  output logic [XLEN-1:0]   ssr_q,
  output logic [XLEN-1:0]   spc_q,
  output logic [XLEN-1:0]   sgr_q,
  output logic [CODE_W-1:0] expevt_q,
  output logic [CODE_W-1:0] intevt_q,
  output logic [2:0]        dslot_q
);
  logic              take;
  logic [CODE_W-1:0] eff_code;
  cause_e            cause;
  logic [XLEN-1:0]   sr_nx, pc_nx, spc_nx;
  logic              ld_exp, ld_int;
  logic [2:0]        dslot_nx;

  assign irq_level = sr_in[SR_IM_LO +: IM_W];

  exc_arbiter #(.CODE_W(CODE_W)) u_arb (
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .irq_req   (irq_req),
    .irq_vector(irq_vector),
    .blocked   (sr_in[SR_BL]),
    .in_sleep  (in_sleep),
    .take      (take),
    .eff_code  (eff_code),
    .cause     (cause)
  );

  exc_target #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tgt (
    .cause   (cause),
    .eff_code(eff_code),
    .sr_in   (sr_in),
    .pc_in   (pc_in),
    .vbr_in  (vbr_in),
    .in_slot (dslot_in[1:0]),
    .sr_nx   (sr_nx),
    .pc_nx   (pc_nx),
    .spc_nx  (spc_nx)
  );

  // next-state decode
  always_comb begin
    ld_exp   = take && (cause != CAUSE_IRQ);
    ld_int   = (cause == CAUSE_IRQ);
    dslot_nx = take ? 3'b000 : dslot_in;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken    <= 1'b0;
      irq_ack  <= 1'b0;
      sr_q     <= '0;
      pc_q     <= '0;
      ssr_q    <= '0;
      spc_q    <= '0;
      sgr_q    <= '0;
      expevt_q <= '0;
      intevt_q <= '0;
      dslot_q  <= '0;
    end else begin
      taken   <= take;
      irq_ack <= ld_int;
      dslot_q <= dslot_nx;
      if (take) begin
        sr_q  <= sr_nx;
        pc_q  <= pc_nx;
        ssr_q <= sr_in;
        spc_q <= spc_nx;
        sgr_q <= r15_in;
      end
      if (ld_exp) expevt_q <= eff_code;
      if (ld_int) intevt_q <= irq_vector;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic              irq_req,
  input logic [CODE_W-1:0] irq_vector,
  input logic [XLEN-1:0]   sr_in,
  input logic [XLEN-1:0]   vbr_in,
  input logic              in_sleep,
  input logic              taken,
  input logic              irq_ack,
  input logic [XLEN-1:0]   sr_q,
  input logic [XLEN-1:0]   pc_q,
  input logic [XLEN-1:0]   ssr_q,
  input logic [CODE_W-1:0] expevt_q,
  input logic [CODE_W-1:0] intevt_q
);
  assert_exc_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (taken && !irq_ack));

  assert_bl_to_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && sr_in[SR_BL] && exc_code != CODE_W'(CODE_KEEP_BL))
      |=> (expevt_q == '0 && pc_q == XLEN'(RESET_PC)));

  assert_irq_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && sr_in[SR_BL] && !in_sleep) |=> !irq_ack);

  assert_entry_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (sr_q[SR_BL] && sr_q[SR_MD] && sr_q[SR_RB] && ssr_q == $past(sr_in)));

  assert_irq_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (intevt_q == $past(irq_vector) && pc_q == $past(vbr_in) + XLEN'(OFS_IRQ)));

  assert_ack_implies_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> taken);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> ($stable(pc_q) && $stable(sr_q) && $stable(expevt_q)));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
  .irq_req(irq_req), .irq_vector(irq_vector), .sr_in(sr_in), .vbr_in(vbr_in),
  .in_sleep(in_sleep), .taken(taken), .irq_ack(irq_ack), .sr_q(sr_q),
  .pc_q(pc_q), .ssr_q(ssr_q), .expevt_q(expevt_q), .intevt_q(intevt_q)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic        clk, rst_n;
  logic        exc_valid, irq_req, in_sleep;
  logic [11:0] exc_code, irq_vector;
  logic [3:0]  irq_level;
  logic [31:0] sr_in, pc_in, vbr_in, r15_in;
  logic [2:0]  dslot_in;
  logic        taken, irq_ack;
  logic [31:0] sr_q, pc_q, ssr_q, spc_q, sgr_q;
  logic [11:0] expevt_q, intevt_q;
  logic [2:0]  dslot_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // expected state
  logic [31:0] m_sr, m_pc, m_ssr, m_spc, m_sgr;
  logic [11:0] m_exp, m_int;
  logic [2:0]  m_ds;
  logic        m_taken, m_ack;

  exc_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .irq_req(irq_req), .irq_vector(irq_vector), .irq_level(irq_level),
    .sr_in(sr_in), .pc_in(pc_in), .vbr_in(vbr_in), .r15_in(r15_in),
    .in_sleep(in_sleep), .dslot_in(dslot_in), .taken(taken), .irq_ack(irq_ack),
    .sr_q(sr_q), .pc_q(pc_q), .ssr_q(ssr_q), .spc_q(spc_q), .sgr_q(sgr_q),
    .expevt_q(expevt_q), .intevt_q(intevt_q), .dslot_q(dslot_q)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] code_at(input int i);
    case (i)
      0: return 12'h000; 1: return 12'h020; 2: return 12'h040; 3: return 12'h060;
      4: return 12'h0E0; 5: return 12'h160; 6: return 12'h1E0; default: return 12'h180;
    endcase
  endfunction

  initial begin
    int idx;
    logic [11:0] ecode;
    logic irq_ok, is_rst;
    string pc_tag, spc_tag;
    rst_n = 0; exc_valid = 0; irq_req = 0; in_sleep = 0; exc_code = 0;
    irq_vector = 0; sr_in = 0; pc_in = 0; vbr_in = 0; r15_in = 0; dslot_in = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset taken", {31'b0, taken}, 0);
    chk("R11", "reset pc", pc_q, 0);
    chk("R11", "reset sr", sr_q, 0);
    chk("R11", "reset expevt", {20'b0, expevt_q}, 0);
    rst_n = 1;
    m_sr = 0; m_pc = 0; m_ssr = 0; m_spc = 0; m_sgr = 0; m_exp = 0; m_int = 0; m_ds = 0;
    idx = 0;
    for (int ci = 0; ci < 8; ci++)
    for (int bl = 0; bl < 2; bl++)
    for (int ds = 0; ds < 3; ds++)
    for (int ev = 0; ev < 2; ev++)
    for (int iq = 0; iq < 2; iq++)
    for (int sl = 0; sl < 2; sl++)
    for (int vv = 0; vv < 2; vv++) begin
      idx++;
      exc_valid  = ev[0];
      exc_code   = code_at(ci);
      irq_req    = iq[0];
      in_sleep   = sl[0];
      irq_vector = vv ? 12'hFFF : 12'h200 + 12'(idx & 12'h1F0);
      dslot_in   = (ds == 0) ? 3'b100 : (ds == 1) ? 3'b001 : 3'b010;
      pc_in      = 32'h0C00_1000 + 32'(idx * 6);
      vbr_in     = 32'h8C00_0000 + 32'(idx * 32'h1000);
      r15_in     = 32'h0000_7000 + 32'(idx * 7);
      sr_in      = (32'(idx) * 32'h0101_0111) & 32'h8FFF_FFFF;
      sr_in[28]  = bl[0];
      #0;
      chk("R3", "irq_level", {28'b0, irq_level}, {28'b0, sr_in[7:4]});
      // model
      ecode  = (bl[0] && exc_code != 12'h1E0) ? 12'h000 : exc_code;
      irq_ok = irq_req && !exc_valid && (!bl[0] || in_sleep) && (irq_vector != 12'hFFF);
      is_rst = exc_valid && (ecode == 12'h000 || ecode == 12'h020);
      m_taken = exc_valid || irq_ok;
      m_ack   = irq_ok;
      m_ds    = m_taken ? 3'b000 : dslot_in;
      pc_tag  = "R7"; spc_tag = "R5";
      if (m_taken) begin
        m_ssr = sr_in;
        m_sgr = r15_in;
        m_spc = pc_in - ((dslot_in[1:0] != 0) ? 32'd2 : 32'd0);
        if (exc_valid && ecode == 12'h160) begin m_spc = m_spc + 2; spc_tag = "R9"; end
        m_sr = sr_in | 32'h7000_0000;
        if (is_rst) begin
          m_sr = (m_sr & ~32'h0000_8000) | 32'h0000_00F0;
          m_pc = 32'hA000_0000;
          pc_tag = (bl[0] && exc_code != ecode) ? "R2" : "R6";
        end else if (exc_valid && (ecode == 12'h040 || ecode == 12'h060)) begin
          m_pc = vbr_in + 32'h400;
        end else if (exc_valid) begin
          m_pc = vbr_in + 32'h100;
          if (bl[0]) pc_tag = "R2";
        end else begin
          m_pc = vbr_in + 32'h600;
          m_int = irq_vector;
          pc_tag = "R8";
        end
        if (exc_valid) m_exp = ecode;
      end else begin
        pc_tag = "R3";
      end
      @(posedge clk);
      @(negedge clk);
      chk(exc_valid ? "R1" : "R11", "taken", {31'b0, taken}, {31'b0, m_taken});
      chk(irq_req ? "R3" : "R1", "irq_ack", {31'b0, irq_ack}, {31'b0, m_ack});
      chk(is_rst ? "R6" : "R4", "sr_q", sr_q, m_sr);
      chk(pc_tag, "pc_q", pc_q, m_pc);
      chk("R4", "ssr_q", ssr_q, m_ssr);
      chk("R4", "sgr_q", sgr_q, m_sgr);
      chk(spc_tag, "spc_q", spc_q, m_spc);
      chk(bl[0] ? "R2" : "R10", "expevt_q", {20'b0, expevt_q}, {20'b0, m_exp});
      chk(exc_valid ? "R10" : "R8", "intevt_q", {20'b0, intevt_q}, {20'b0, m_int});
      chk("R5", "dslot_q", {29'b0, dslot_q}, {29'b0, m_ds});
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule